// File: doc/BRIEF.md
# State-Parallel Add-Compare-Select Array

This block is the metric-update core of a 16-state Viterbi decoder for a rate-1/2 convolutional code with constraint length 5 (generators 23 and 35 octal). Every state has its own add-compare-select cell. On each accepted step the array takes four 5-bit branch metrics, one for each possible 2-bit code word. It forms both candidate path metrics for every state, keeps the smaller one and writes all 16 results into an 8-bit-per-state metric register. That register feeds back into the cells.

Metrics are not normalized. Each addition saturates at the all-ones value. The block also emits a 16-bit vector of survivor decisions, one bit per state, for a downstream path memory. Branch metric calculation, survivor storage and traceback sit outside the block.

Top module: `acs_array`

## Requirements
- R1: While rst_ni is low, and after it is released, the metric of state 0 reads 0 and the metrics of states 1 to 15 read 255. rst_ni is asynchronous and active low.
- R2: When valid_i is low at a rising clock edge, all 16 metrics keep their values. dec_valid_o is low in that cycle.
- R3: State n has two predecessors. The upper one is p_up = {n[2:0],0} and the lower one is p_lo = {n[2:0],1}. The input bit on both transitions is u = n[3]. The upper candidate is metric[p_up] plus the branch metric of that transition. The lower candidate is built the same way from p_lo.
- R4: dec_o[n] is 0 when the upper candidate is less than or equal to the lower candidate, so ties go to the upper path, and 1 otherwise. When valid_i is high, state n's metric after the edge is the candidate that dec_o[n] selects.
- R5: For a transition from state s with input u, the branch metric index is {c1,c0}. Here w = {u,s[3:0]}, c0 = ^(w & 5'b10011) and c1 = ^(w & 5'b11101). Branch metric i occupies bm_i[5*i+4:5*i].
- R6: dec_o is valid in the same cycle that valid_i is high, and dec_valid_o equals valid_i.
- R7: A candidate sum above 255 is clamped to 255 and never wraps.
- R8: The metric of state n occupies sm_o[8*n+7:8*n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Accept branch metrics and update the state metrics |
| bm_i | input | 20 | Four packed 5-bit branch metrics, index 0 in the low bits |
| sm_o | output | 128 | Sixteen packed 8-bit state metrics |
| dec_o | output | 16 | Survivor decision per state (1 = lower predecessor) |
| dec_valid_o | output | 1 | dec_o is valid this cycle |

## Verification
On every cycle the assertions check four things. Metrics stay unchanged when no step is accepted. A saturating candidate never falls below its predecessor metric. A tie always chooses the upper path. Each updated metric is no larger than either candidate of the previous cycle. Whether the trellis wiring and branch-metric index are correct can only be shown by the bench's scenarios, which compare every metric and decision with an independent reference model. The same applies to the reset constants and to the clamping at 255 under long runs of large metrics.

// File: rtl/acs_array_pkg.sv
package acs_array_pkg;
  localparam int unsigned CL    = 5;
  localparam int unsigned MEM_W = CL - 1;
  localparam int unsigned NS    = 1 << MEM_W;
  localparam int unsigned BM_W  = 5;
  localparam int unsigned SM_W  = 8;
  localparam int unsigned NBM   = 4;
  localparam logic [CL-1:0] GEN_A = 5'o23;
  localparam logic [CL-1:0] GEN_B = 5'o35;

  // R5: code word of a transition selects the branch metric
  function automatic logic [1:0] bm_index(input logic [MEM_W-1:0] s, input logic u);
    logic [CL-1:0] w;
    w = {u, s};
    return {^(w & GEN_B), ^(w & GEN_A)};
  endfunction
endpackage

// File: rtl/acs_sat_add.sv
module acs_sat_add #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 5
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] s_o
);
  logic [A_W:0] full;

  always_comb begin
    full = {1'b0, a_i} + {{(A_W + 1 - B_W){1'b0}}, b_i};
    s_o  = full[A_W] ? {A_W{1'b1}} : full[A_W-1:0];
  end
endmodule

// File: rtl/acs_cell.sv
module acs_cell #(
  parameter int unsigned SM_W = 8,
  parameter int unsigned BM_W = 5
) (
  input  logic [SM_W-1:0] sm_up_i,
  input  logic [SM_W-1:0] sm_lo_i,
  input  logic [BM_W-1:0] bm_up_i,
  input  logic [BM_W-1:0] bm_lo_i,
  output logic [SM_W-1:0] cand_up_o,
  output logic [SM_W-1:0] cand_lo_o,
  output logic [SM_W-1:0] nsm_o,
  output logic            sel_o
);
  acs_sat_add #(.A_W(SM_W), .B_W(BM_W)) u_add_up (
    .a_i(sm_up_i), .b_i(bm_up_i), .s_o(cand_up_o)
  );
  acs_sat_add #(.A_W(SM_W), .B_W(BM_W)) u_add_lo (
    .a_i(sm_lo_i), .b_i(bm_lo_i), .s_o(cand_lo_o)
  );

  // ties keep the upper path
  always_comb begin
    sel_o = (cand_up_o > cand_lo_o);
    nsm_o = sel_o ? cand_lo_o : cand_up_o;
  end
endmodule

// File: rtl/acs_metric_reg.sv
module acs_metric_reg #(
  parameter int unsigned NS   = 16,
  parameter int unsigned SM_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [NS*SM_W-1:0]   d_i,
  output logic [NS*SM_W-1:0]   q_o
);
  for (genvar n = 0; n < NS; n++) begin : g_st
    localparam logic [SM_W-1:0] INIT = (n == 0) ? '0 : {SM_W{1'b1}};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[n*SM_W +: SM_W] <= INIT;
      else if (en_i) q_o[n*SM_W +: SM_W] <= d_i[n*SM_W +: SM_W];
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/acs_array.sv
module acs_array
  import acs_array_pkg::*;
#(
  parameter int unsigned K     = CL,
  parameter int unsigned BMW   = BM_W,
  parameter int unsigned SMW   = SM_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [4*BMW-1:0]              bm_i,
  output logic [(1<<(K-1))*SMW-1:0]     sm_o,
  output logic [(1<<(K-1))-1:0]         dec_o,
  output logic                          dec_valid_o
);
  localparam int unsigned MW  = K - 1;
  localparam int unsigned NST = 1 << MW;

  logic [NST*SMW-1:0] nsm;
  logic [SMW-1:0]     cand_up [NST];
  logic [SMW-1:0]     cand_lo [NST];

  for (genvar n = 0; n < NST; n++) begin : g_acs
    localparam logic [MW-1:0] NS_ID = MW'(n);
    localparam logic          U     = NS_ID[MW-1];
    localparam logic [MW-1:0] P_UP  = {NS_ID[MW-2:0], 1'b0};
    localparam logic [MW-1:0] P_LO  = {NS_ID[MW-2:0], 1'b1};
    localparam logic [1:0]    I_UP  = bm_index(P_UP, U);
    localparam logic [1:0]    I_LO  = bm_index(P_LO, U);

    acs_cell #(.SM_W(SMW), .BM_W(BMW)) u_cell (
      .sm_up_i  (sm_o[P_UP*SMW +: SMW]),
      .sm_lo_i  (sm_o[P_LO*SMW +: SMW]),
      .bm_up_i  (bm_i[I_UP*BMW +: BMW]),
      .bm_lo_i  (bm_i[I_LO*BMW +: BMW]),
      .cand_up_o(cand_up[n]),
      .cand_lo_o(cand_lo[n]),
      .nsm_o    (nsm[n*SMW +: SMW]),
      .sel_o    (dec_o[n])
    );

    // R7
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_up[n] >= sm_o[P_UP*SMW +: SMW] && cand_lo[n] >= sm_o[P_LO*SMW +: SMW]);
    // R4
    tie_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cand_up[n] == cand_lo[n]) |-> !dec_o[n]);
    // R4
    keep_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (sm_o[n*SMW +: SMW] <= $past(cand_up[n]))
               && (sm_o[n*SMW +: SMW] <= $past(cand_lo[n])));
  end

  acs_metric_reg #(.NS(NST), .SM_W(SMW)) u_sm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (nsm),
    .q_o   (sm_o)
  );

  assign dec_valid_o = valid_i;
endmodule

// File: tb/acs_array_tb.sv
`timescale 1ns/1ps
module acs_array_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [19:0]  bm = '0;
  logic [127:0] sm;
  logic [15:0]  dec;
  logic         dec_v;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ref_sm [16];
  logic [7:0] ref_nx [16];
  logic [15:0] ref_dec;
  logic [3:0]  enc_st = '0;

  always #4 clk = ~clk;

  acs_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bm_i(bm),
    .sm_o(sm), .dec_o(dec), .dec_valid_o(dec_v)
  );

  function automatic logic [1:0] code_word(input logic [3:0] s, input logic u);
    logic [4:0] w;
    w = {u, s};
    return {^(w & 5'b11101), ^(w & 5'b10011)};
  endfunction

  function automatic logic [7:0] sadd(input logic [7:0] a, input logic [4:0] b);
    int t;
    t = int'(a) + int'(b);
    return (t > 255) ? 8'd255 : t[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference step: R3 R4 R5 R7
  task automatic ref_step();
    for (int n = 0; n < 16; n++) begin
      logic [3:0] pu, pl;
      logic       u;
      logic [7:0] cu, cl;
      u  = n[3];
      pu = {n[2:0], 1'b0};
      pl = {n[2:0], 1'b1};
      cu = sadd(ref_sm[pu], bm[5*code_word(pu, u) +: 5]);
      cl = sadd(ref_sm[pl], bm[5*code_word(pl, u) +: 5]);
      ref_dec[n] = (cu > cl);
      ref_nx[n]  = (cu > cl) ? cl : cu;
    end
  endtask

  task automatic check_metrics(input string req);
    for (int n = 0; n < 16; n++) chk(req, 32'(sm[8*n +: 8]), 32'(ref_sm[n]));
  endtask

  // drive at negedge; decisions checked before the next rising edge
  task automatic step(input logic v, input logic [19:0] b, input string req);
    @(negedge clk);
    check_metrics({req, " R8 metrics"});
    valid = v;
    bm    = b;
    #1;
    ref_step();
    chk({req, " R6 dec_valid"}, 32'(dec_v), 32'(v));
    if (v) begin
      chk({req, " R4 R5 decisions"}, 32'(dec), 32'(ref_dec));
      for (int n = 0; n < 16; n++) ref_sm[n] = ref_nx[n];
    end
  endtask

  function automatic logic [19:0] ideal_bm(input logic [1:0] rx);
    logic [19:0] r;
    for (int i = 0; i < 4; i++)
      r[5*i +: 5] = 5'(6 * ($countones(2'(i) ^ rx)));
    return r;
  endfunction

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int n = 0; n < 16; n++) ref_sm[n] = (n == 0) ? 8'd0 : 8'd255;
    #10;
    // R1 during reset
    check_metrics("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_metrics("R1 after release");

    // R5 one-hot zero branch metric per index
    for (int k = 0; k < 4; k++) begin
      logic [19:0] b;
      b = {4{5'd31}};
      b[5*k +: 5] = 5'd0;
      step(1'b1, b, "R5 onehot");
    end

    // R4 ties: all branch metrics equal
    for (int i = 0; i < 4; i++) step(1'b1, {4{5'd3}}, "R4 tie");

    // R2 hold with random metrics on the bus
    for (int i = 0; i < 5; i++) step(1'b0, 20'($urandom), "R2 hold");

    // R7 saturation under maximum branch metrics
    for (int i = 0; i < 12; i++) step(1'b1, {4{5'd31}}, "R7 saturate");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b0;
    #1;
    for (int n = 0; n < 16; n++) ref_sm[n] = (n == 0) ? 8'd0 : 8'd255;
    check_metrics("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R3 encoded random bits with ideal metrics and rare errors
    for (int i = 0; i < 200; i++) begin
      logic u;
      logic [1:0] rx;
      u  = 1'($urandom);
      rx = code_word(enc_st, u);
      if ($urandom_range(0, 9) == 0) rx ^= 2'($urandom_range(1, 3));
      enc_st = {u, enc_st[3:1]};
      step(($urandom_range(0, 7) != 0), ideal_bm(rx), "R3 encoded");
    end

    // R3 fully random metrics
    for (int i = 0; i < 200; i++) step(1'($urandom), 20'($urandom), "R3 random");

    @(negedge clk);
    check_metrics("R8 final");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule